// File: doc/BRIEF.md
# Predicated Vector Load/Store Engine

This block carries out a single vector memory operation of `LANES` elements at a time. It sits between a vector register operand interface and a simple synchronous, word-addressed memory port. The caller supplies a base word address, an operation kind (load or store), a per-lane enable mask, the store data, a pass-through vector and a fill-mode flag, and then pulses `start_i`. Lane `i` maps to memory word `base + i`.

Only enabled lanes reach memory. They are issued one word per cycle, in ascending lane order, so disabled lanes cost neither bandwidth nor cycles. On a load, enabled lanes receive memory data. Disabled lanes are filled from the pass-through vector (merge mode) or are cleared (zeroing mode). On a store, only enabled words are written and every other word keeps its contents. An empty mask finishes at once without touching memory.

Top module: `mvec_lsu`

## Requirements
- R1: Mask bit `i` enables lane `i`, with lane `i` at bits `[i*ELEM_W +: ELEM_W]` of every vector port and lane 0 the least significant. The block requests exactly the enabled lanes, one request per cycle, in strictly ascending lane order, to address `base_i + i`. The first request appears in the cycle after `start_i` is accepted.
- R2: On a load (`store_i` = 0), each enabled lane of `rdata_o` holds the memory word at `base_i + i`. Read data returns one cycle after its request.
- R3: On a load in merge mode (`zero_fill_i` = 0), each disabled lane of `rdata_o` equals the matching lane of `pass_i`.
- R4: On a load in zeroing mode (`zero_fill_i` = 1), each disabled lane of `rdata_o` is zero.
- R5: On a store (`store_i` = 1), each enabled lane writes its `wdata_i` lane to `base_i + i`. Memory words of disabled lanes are left unchanged.
- R6: An all-zero mask issues no memory request. `done_o` is high in the cycle after acceptance, and `busy_o` never rises. For a load, `rdata_o` then holds the fill value in every lane.
- R7: An all-ones mask performs a contiguous access of `LANES` words, `base_i` to `base_i + LANES - 1`, in `LANES` consecutive cycles.
- R8: `done_o` is a one-cycle pulse. For a store it comes one cycle after the last write request. For a load it comes two cycles after the last read request. `rdata_o` is complete from that cycle until the next accepted start.
- R9: `start_i` is accepted only while `busy_o` is low. A start seen while busy has no effect on the ongoing request sequence and launches no further operation.
- R10: After reset, `busy_o`, `done_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| store_i | input | 1 | 1 = store, 0 = load |
| zero_fill_i | input | 1 | Load fill mode for disabled lanes: 1 = zero, 0 = pass-through |
| mask_i | input | LANES | Per-lane enable |
| base_i | input | ADDR_W | Word address of lane 0 |
| wdata_i | input | LANES*ELEM_W | Store data vector |
| pass_i | input | LANES*ELEM_W | Pass-through vector for disabled load lanes |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | LANES*ELEM_W | Load result vector |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | ELEM_W | Memory write data |
| mem_rdata_i | input | ELEM_W | Memory read data, one cycle after the request |

## Verification
Loads run with a sparse mask in both merge and zeroing mode. This separates the two fill sources from memory data, since the pass-through values, zero and memory contents all differ. Stores run with a sparse mask over pre-filled memory, which exposes any write to a disabled word. All-ones masks check the contiguous case and the full cycle count. All-zero masks check for silence on the memory port and the early completion. A mask holding only the top lane checks the ordering and latency edge. A start pulse during a busy store checks that the operation in flight is undisturbed.

// File: rtl/mvec_lsu_pkg.sv
package mvec_lsu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } lsu_state_e;
endpackage

// File: rtl/mvec_lane_pick.sv
module mvec_lane_pick #(
  parameter int LANES = 8,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] pend_i,
  output logic [LW-1:0]    idx_o,
  output logic [LANES-1:0] onehot_o
);
  always_comb begin
    idx_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = LW'(i);
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_oh
      assign onehot_o[g] = pend_i[g] && (idx_o == LW'(g));
    end
  endgenerate
endmodule

// File: rtl/mvec_lane_bank.sv
module mvec_lane_bank #(
  parameter int LANES  = 8,
  parameter int ELEM_W = 32,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    init_en_i,
  input  logic [LANES*ELEM_W-1:0] init_i,
  input  logic                    wr_en_i,
  input  logic [LW-1:0]           wr_lane_i,
  input  logic [ELEM_W-1:0]       wr_data_i,
  output logic [LANES*ELEM_W-1:0] data_o
);
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [ELEM_W-1:0] q, d;
      logic              en;
      always_comb begin
        en = init_en_i || (wr_en_i && (wr_lane_i == LW'(g)));
        d  = init_en_i ? init_i[g*ELEM_W +: ELEM_W] : wr_data_i;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
      end
      assign data_o[g*ELEM_W +: ELEM_W] = q;
    end
  endgenerate
endmodule

// File: rtl/mvec_lsu.sv
module mvec_lsu
  import mvec_lsu_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ELEM_W = 32,
  parameter int ADDR_W = 16,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int VW = LANES * ELEM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               store_i,
  input  logic               zero_fill_i,
  input  logic [LANES-1:0]   mask_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [VW-1:0]      wdata_i,
  input  logic [VW-1:0]      pass_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [VW-1:0]      rdata_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [ELEM_W-1:0]  mem_wdata_o,
  input  logic [ELEM_W-1:0]  mem_rdata_i
);
  lsu_state_e        state_q, state_d;
  logic [LANES-1:0]  pend_q, pend_d;
  logic              store_q;
  logic [ADDR_W-1:0] base_q;
  logic [VW-1:0]     wdat_q;
  logic              done_q, done_d;
  logic              rd_vld_q, rd_vld_d;
  logic [LW-1:0]     rd_lane_q;
  logic [LW-1:0]     pick_idx;
  logic [LANES-1:0]  pick_oh;
  logic [VW-1:0]     fill_vec;
  logic              accept;

  assign accept = start_i && (state_q == ST_IDLE);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_fill
      assign fill_vec[g*ELEM_W +: ELEM_W] =
        zero_fill_i ? '0 : pass_i[g*ELEM_W +: ELEM_W];
    end
  endgenerate

  mvec_lane_pick #(.LANES(LANES)) u_pick (
    .pend_i   (pend_q),
    .idx_o    (pick_idx),
    .onehot_o (pick_oh)
  );

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    pend_d      = pend_q;
    done_d      = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = base_q + {{(ADDR_W-LW){1'b0}}, pick_idx};
    mem_wdata_o = wdat_q[pick_idx*ELEM_W +: ELEM_W];
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          pend_d = mask_i;
          if (mask_i == '0) done_d = 1'b1;
          else              state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        mem_req_o = 1'b1;
        mem_we_o  = store_q;
        pend_d    = pend_q & ~pick_oh;
        if (pend_d == '0) begin
          if (store_q) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_TAIL;
          end
        end
      end
      ST_TAIL: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    rd_vld_d = mem_req_o && !store_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pend_q    <= '0;
      done_q    <= 1'b0;
      rd_vld_q  <= 1'b0;
      rd_lane_q <= '0;
    end else begin
      state_q   <= state_d;
      pend_q    <= pend_d;
      done_q    <= done_d;
      rd_vld_q  <= rd_vld_d;
      rd_lane_q <= pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= 1'b0;
      base_q  <= '0;
      wdat_q  <= '0;
    end else if (accept) begin
      store_q <= store_i;
      base_q  <= base_i;
      wdat_q  <= wdata_i;
    end
  end

  mvec_lane_bank #(.LANES(LANES), .ELEM_W(ELEM_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_en_i (accept),
    .init_i    (fill_vec),
    .wr_en_i   (rd_vld_q),
    .wr_lane_i (rd_lane_q),
    .wr_data_i (mem_rdata_i),
    .data_o    (rdata_o)
  );

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  // Assertions
  a_r1_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && $past(mem_req_o)) |-> (pick_idx > $past(pick_idx)));

  a_r1_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);

  a_r6_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (mask_i == '0)) |=> (done_o && !busy_o && !mem_req_o));

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !mem_req_o));

  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(store_q) && $stable(base_q) && $stable(wdat_q)));

  a_r2_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |=> rd_vld_q);
endmodule

// File: tb/tb_mvec_lsu.sv
`timescale 1ns/1ps
module tb_mvec_lsu;
  localparam int N  = 8;
  localparam int W  = 32;
  localparam int AW = 16;
  localparam int MW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, store_i = 1'b0, zero_fill_i = 1'b0;
  logic [N-1:0] mask_i = '0;
  logic [AW-1:0] base_i = '0;
  logic [N*W-1:0] wdata_i = '0, pass_i = '0;
  logic busy_o, done_o, mem_req_o, mem_we_o;
  logic [N*W-1:0] rdata_o;
  logic [AW-1:0] mem_addr_o;
  logic [W-1:0] mem_wdata_o, mem_rdata_i;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mvec_lsu #(.LANES(N), .ELEM_W(W), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .store_i(store_i),
    .zero_fill_i(zero_fill_i), .mask_i(mask_i), .base_i(base_i),
    .wdata_i(wdata_i), .pass_i(pass_i), .busy_o(busy_o), .done_o(done_o),
    .rdata_o(rdata_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  // Memory at the port: one-cycle read latency
  logic [W-1:0] mem [MW];
  logic [W-1:0] exp_mem [MW];
  logic [W-1:0] rdq = '0;
  assign mem_rdata_i = rdq;
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o[5:0]] <= mem_wdata_o;
      else          rdq <= mem[mem_addr_o[5:0]];
    end
  end

  task automatic check(input string req, input bit ok, input logic [N*W-1:0] act,
                       input logic [N*W-1:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic run(input bit st, input bit zf, input logic [N-1:0] m,
                     input int base, input logic [N*W-1:0] wd,
                     input logic [N*W-1:0] pt, input bit poke);
    int en [N];
    int nen = 0;
    int dc;
    bit cyc_ok = 1'b1;
    bit done_ok = 1'b1;
    logic [N*W-1:0] exp_rd;
    for (int i = 0; i < N; i++) begin
      if (m[i]) begin en[nen] = i; nen++; end
      exp_rd[i*W +: W] = m[i] ? exp_mem[base+i] : (zf ? '0 : pt[i*W +: W]);
    end
    dc = (nen == 0) ? 1 : (st ? nen + 1 : nen + 2);
    @(negedge clk);
    start_i = 1'b1; store_i = st; zero_fill_i = zf; mask_i = m;
    base_i = AW'(base); wdata_i = wd; pass_i = pt;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 1; c <= dc + 2; c++) begin
      // cycle-by-cycle model comparison
      if (c <= nen) begin
        if (!(mem_req_o && mem_we_o == st && mem_addr_o == AW'(base + en[c-1]) &&
              (!st || mem_wdata_o == wd[en[c-1]*W +: W]))) begin
          cyc_ok = 1'b0;
          $display("FAIL R1 cycle %0d actual addr=%0d req=%0b expected addr=%0d req=1",
                   c, mem_addr_o, mem_req_o, base + en[c-1]);
        end
        if (st) exp_mem[base + en[c-1]] = wd[en[c-1]*W +: W];
      end else if (mem_req_o) begin
        cyc_ok = 1'b0;
        $display("FAIL R1 cycle %0d actual req=1 expected req=0", c);
      end
      if (done_o !== (c == dc)) begin
        done_ok = 1'b0;
        $display("FAIL R8 cycle %0d actual done=%0b expected done=%0b", c, done_o, c == dc);
      end
      if (c == dc && !st)
        check(zf ? "R4 fill/R2 data" : "R3 fill/R2 data", rdata_o == exp_rd, rdata_o, exp_rd);
      if (poke && c == 3) begin
        start_i = 1'b1; store_i = 1'b0; mask_i = '1; base_i = 16'd0;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    check("R1 request trace", cyc_ok, '0, '0);
    check("R8 done timing", done_ok, '0, '0);
    begin
      bit mok = 1'b1;
      for (int a = 0; a < MW; a++) if (mem[a] !== exp_mem[a]) mok = 1'b0;
      check("R5 memory contents", mok, '0, '0);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [N*W-1:0] pt, wd;
    for (int a = 0; a < MW; a++) begin
      mem[a] = 32'hA000_0000 + 32'(a);
      exp_mem[a] = mem[a];
    end
    for (int i = 0; i < N; i++) begin
      pt[i*W +: W] = 32'hBEEF_0000 + 32'(i);
      wd[i*W +: W] = 32'h5100_0000 + 32'(i * 17);
    end
    repeat (3) @(negedge clk);
    check("R10 reset", !busy_o && !done_o && !mem_req_o, {busy_o, done_o, mem_req_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", !busy_o && !done_o && !mem_req_o, {busy_o, done_o, mem_req_o}, '0);

    run(1'b0, 1'b0, 8'b1011_1100, 4, wd, pt, 1'b0);   // R2 R3 sparse merge load
    run(1'b0, 1'b1, 8'b1011_1100, 4, wd, pt, 1'b0);   // R4 zeroing load
    run(1'b1, 1'b0, 8'b0101_0011, 20, wd, pt, 1'b0);  // R5 sparse store
    run(1'b0, 1'b0, 8'hFF, 10, wd, pt, 1'b0);         // R7 full load
    run(1'b1, 1'b0, 8'hFF, 40, wd, pt, 1'b0);         // R7 full store
    run(1'b0, 1'b0, 8'h00, 8, wd, pt, 1'b0);          // R6 empty merge
    run(1'b0, 1'b1, 8'h00, 8, wd, pt, 1'b0);          // R6 empty zeroing
    run(1'b1, 1'b0, 8'h00, 30, wd, pt, 1'b0);         // R6 empty store
    run(1'b0, 1'b1, 8'b1000_0000, 50, wd, pt, 1'b0);  // R1 top lane only
    wd = ~wd;
    run(1'b1, 1'b0, 8'b1110_0101, 52, wd, pt, 1'b1);  // R9 start while busy
    run(1'b0, 1'b0, 8'b0110_1001, 20, wd, pt, 1'b0);  // read back stored words
    check("R9 idle after ignored start", !busy_o && !mem_req_o, {busy_o, mem_req_o}, '0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule